// File: doc/BRIEF.md
# One-Shot Delay Interrupt Generator

This block is one control and status word inside a host controller's register space. Software programs a delay limit and sets a start bit. An 8-bit counter then runs on the bus interface clock. When the count reaches the limit, the block sends out one interrupt pulse that lasts a single clock. In the same cycle it drops the start bit without any further software action.

While the count runs, software can read the live counter value and a completion flag from the same word. It can cancel a pending request by writing the start bit back to zero. It can also raise or lower the limit in mid-count. Once the trigger has fired, the completion flag and the final count stay visible until the next start or a reset.

Top module: `oneshot_delay_irq`

## Requirements
- R1: After reset, the word reads 0x000000FF: limit 0xFF in bits 7:0, and start, count and completion flag all 0. The interrupt output is low.
- R2: The word answers only at byte address 0x120. A write to any other address changes nothing, and a read from any other address returns 0.
- R3: A write that takes the start bit (bit 8) from 0 to 1 clears the counter (bits 23:16) and the completion flag (bit 24) at that clock edge. After that, the counter adds one on every clock.
- R4: With limit M, the interrupt output rises exactly M+1 clock edges after the starting write's edge and stays high for exactly one cycle. A limit of 0 therefore fires one edge after the start.
- R5: The start bit reads 0 from the edge that raises the interrupt. No further interrupt comes until software sets the start bit again.
- R6: The completion flag sets together with the interrupt. The flag and the final count hold their values until the next start.
- R7: Bits 31:25 and 15:9 read as zero. Writes to those bits, and to the read-only count and flag fields, have no effect.
- R8: Writing 0 to the start bit while a count runs stops the count. No interrupt follows, the completion flag stays 0 and the count holds its value.
- R9: A limit written during a count is used in the comparison from the next clock on.
- R10: Writing 1 to the start bit while a count already runs does not restart the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Byte address of the access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from the address |
| irqPulse | output | 1 | One-cycle interrupt trigger |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 12-bit address and the word at 0x120. These values let the bench reach the full counter range. It runs limits of 0, small values and 0xFF, where the longest count runs 256 edges. Because the field positions are fixed at these values, the bench can check every readback against exact words. The bench also covers the writes that race a running count: a cancel, a limit change and a repeated start.

// File: rtl/oneshot_delay_irq_pkg.sv
package oneshot_delay_irq_pkg;

  // Field positions that software decodes
  localparam int MAX_LSB   = 0;
  localparam int START_POS = 8;
  localparam int CNT_LSB   = 16;
  localparam int DONE_POS  = 24;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadMax;
    logic clrCount;
    logic incCount;
    logic fire;
  } dpStrobe_t;

endpackage

// File: rtl/oneshot_delay_irq_ctrl.sv
module oneshot_delay_irq_ctrl
  import oneshot_delay_irq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              wrStart,
  input  logic              cntAtMax,
  output dpStrobe_t         strobe,
  output logic              startBit,
  output logic              irqPulse
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state, stateNext;
  logic       wrHit;

  assign wrHit    = regWrEn && (regAddr == ADDR_W'(REG_OFFSET));
  assign startBit = (state == ST_RUN);

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    strobe.loadMax = wrHit;
    unique case (state)
      ST_IDLE: begin
        if (wrHit && wrStart) begin
          stateNext       = ST_RUN;
          strobe.clrCount = 1'b1;
        end
      end
      ST_RUN: begin
        if (wrHit && !wrStart) begin
          stateNext = ST_IDLE;          // cancel, no trigger
        end else if (cntAtMax) begin
          stateNext   = ST_IDLE;        // self-clear on trigger
          strobe.fire = 1'b1;
        end else begin
          strobe.incCount = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      irqPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      irqPulse <= strobe.fire;
    end
  end

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  p_start_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !startBit);

  p_cancel_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && startBit && !wrStart) |=> (!irqPulse && !startBit));

  p_rerun_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && startBit && wrStart) |-> !strobe.clrCount);

endmodule

// File: rtl/oneshot_delay_irq_dp.sv
module oneshot_delay_irq_dp
  import oneshot_delay_irq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MAX_RESET = 'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrMax,
  output logic             cntAtMax,
  output logic [CNT_W-1:0] maxVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             doneFlag
);

  logic [CNT_W-1:0] maxReg, cntReg;
  logic             doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxReg  <= CNT_W'(MAX_RESET);
      cntReg  <= '0;
      doneReg <= 1'b0;
    end else begin
      if (strobe.loadMax) maxReg <= wrMax;
      if (strobe.clrCount)      cntReg <= '0;
      else if (strobe.incCount) cntReg <= cntReg + 1'b1;
      if (strobe.clrCount)  doneReg <= 1'b0;
      else if (strobe.fire) doneReg <= 1'b1;
    end
  end

  assign cntAtMax = (cntReg == maxReg);
  assign maxVal   = maxReg;
  assign cntVal   = cntReg;
  assign doneFlag = doneReg;

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incCount |=> (cntReg == CNT_W'($past(cntReg) + 1'b1)));

  p_count_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCount |=> (cntReg == '0 && !doneReg));

  p_done_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> doneReg);

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrCount && !strobe.incCount) |=> ($stable(cntReg) && (doneReg || !$past(doneReg))));

endmodule

// File: rtl/oneshot_delay_irq.sv
module oneshot_delay_irq
  import oneshot_delay_irq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h120,
  parameter int CNT_W      = 8,
  parameter int MAX_RESET  = 'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqPulse
);

  dpStrobe_t        strobe;
  logic             startBit, cntAtMax, doneFlag;
  logic [CNT_W-1:0] maxVal, cntVal;
  logic             rdHit;

  oneshot_delay_irq_ctrl #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .wrStart (regWrData[START_POS]),
    .cntAtMax(cntAtMax),
    .strobe  (strobe),
    .startBit(startBit),
    .irqPulse(irqPulse)
  );

  oneshot_delay_irq_dp #(
    .CNT_W    (CNT_W),
    .MAX_RESET(MAX_RESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrMax   (regWrData[MAX_LSB +: CNT_W]),
    .cntAtMax(cntAtMax),
    .maxVal  (maxVal),
    .cntVal  (cntVal),
    .doneFlag(doneFlag)
  );

  assign rdHit = (regAddr == ADDR_W'(REG_OFFSET));

  always_comb begin
    regRdData = '0;
    if (rdHit) begin
      regRdData[MAX_LSB +: CNT_W] = maxVal;
      regRdData[START_POS]        = startBit;
      regRdData[CNT_LSB +: CNT_W] = cntVal;
      regRdData[DONE_POS]         = doneFlag;
    end
  end

endmodule

// File: tb/oneshot_delay_irq_tb.sv
module oneshot_delay_irq_tb;

  localparam logic [11:0] ADDR = 12'h120;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = ADDR;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqPulse;

  int checks = 0;
  int errors = 0;

  oneshot_delay_irq u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqPulse(irqPulse)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regAddr = ADDR; regWrData = '0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData; regAddr = ADDR;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic expectIrqAfter(input string req, input int n);
    int seen = 0;
    for (int i = 1; i <= n + 3; i++) begin
      @(posedge clk); @(negedge clk);
      if (irqPulse && seen == 0) seen = i;
      else if (seen != 0 && i == seen + 1) begin
        check({req, " pulse width"}, 32'(irqPulse), 32'd0);
        break;
      end
    end
    check({req, " trigger edge"}, 32'(seen), 32'(n));
  endtask

  task automatic expectNoIrq(input string req, input int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (irqPulse) hits++;
    end
    check({req, " no interrupt"}, 32'(hits), 32'd0);
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(ADDR, d);
    check("R1 reset word", d, 32'h000000FF);
    check("R1 reset irq", 32'(irqPulse), 32'd0);
  endtask

  task automatic testBasic();
    logic [31:0] d;
    regWrite(ADDR, 32'h0000_0105);
    regRead(ADDR, d);
    check("R3 start clears count", d, 32'h0000_0105);
    expectIrqAfter("R4 limit 5", 6);
    regRead(ADDR, d);
    check("R5 R6 after trigger", d, 32'h0105_0005);
    expectNoIrq("R5 single trigger", 10);
    regRead(ADDR, d);
    check("R6 held state", d, 32'h0105_0005);
  endtask

  task automatic testZero();
    logic [31:0] d;
    regWrite(ADDR, 32'h0000_0100);
    expectIrqAfter("R4 limit 0", 1);
    regRead(ADDR, d);
    check("R6 limit 0 result", d, 32'h0100_0000);
  endtask

  task automatic testRestart();
    logic [31:0] d;
    regWrite(ADDR, 32'h0000_0103);
    regRead(ADDR, d);
    check("R3 restart clears done", d, 32'h0000_0103);
    waitEdges(2);
    regRead(ADDR, d);
    check("R3 count increments", d, 32'h0002_0103);
    expectIrqAfter("R4 restart limit 3", 2);
  endtask

  task automatic testCancel();
    logic [31:0] d;
    regWrite(ADDR, 32'h0000_010A);
    waitEdges(3);
    regWrite(ADDR, 32'h0000_000A);
    regRead(ADDR, d);
    check("R8 cancel holds count", d, 32'h0003_000A);
    expectNoIrq("R8 cancel", 20);
    regRead(ADDR, d);
    check("R8 done stays clear", d, 32'h0003_000A);
  endtask

  task automatic testMaxChange();
    logic [31:0] d;
    regWrite(ADDR, 32'h0000_0114);
    waitEdges(2);
    regWrite(ADDR, 32'h0000_0104);
    regRead(ADDR, d);
    check("R10 rewrite keeps counting", d, 32'h0003_0104);
    expectIrqAfter("R9 new limit", 2);
    regRead(ADDR, d);
    check("R9 final state", d, 32'h0104_0004);
  endtask

  task automatic testReserved();
    logic [31:0] d;
    regWrite(ADDR, 32'hFEAA_FE07);
    regRead(ADDR, d);
    check("R7 reserved and RO fields", d, 32'h0104_0007);
    expectNoIrq("R7 no start", 4);
  endtask

  task automatic testOtherAddr();
    logic [31:0] d;
    regWrite(12'h124, 32'h0000_01FF);
    regRead(ADDR, d);
    check("R2 write elsewhere ignored", d, 32'h0104_0007);
    regRead(12'h124, d);
    check("R2 read elsewhere", d, 32'h0);
    expectNoIrq("R2 no start", 5);
  endtask

  task automatic testFull();
    logic [31:0] d;
    regWrite(ADDR, 32'h0000_01FF);
    expectIrqAfter("R4 limit 0xFF", 256);
    regRead(ADDR, d);
    check("R6 limit 0xFF result", d, 32'h01FF_00FF);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testZero();
    testRestart();
    testCancel();
    testMaxChange();
    testReserved();
    testOtherAddr();
    testFull();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule